// File: doc/BRIEF.md
# FIFO threshold DMA request controller

This block sits next to a data FIFO in a disk-interface bridge and decides when a DMA controller should top the FIFO up or empty it. It holds one programmable alarm threshold. It compares that threshold against the FIFO's current fill level and raises one of two requests. The refill request fires when the FIFO has dropped below the threshold. The drain request fires when the FIFO has reached it. Each request has its own enable input, which comes from a control register outside this block.

The block also keeps two sticky error flags, one for FIFO overflow and one for FIFO underflow. Each flag is set by a single-cycle event pulse. Software clears a flag by writing a one to its bit in a write-only clear register. Both registers are reached through a simple byte-wide bus. Writes take effect at the clock edge, and reads return data combinationally while the read strobe is high.

Top module: `fta_ctrl`

## Requirements
- R1: After reset the alarm threshold reads 0, both sticky flags are 0 and both requests are 0.
- R2: The alarm threshold sits at byte offset 0x34. All 8 bits can be written and read back.
- R3: The refill request is 1 exactly when the refill enable and fill level sampled at the previous clock edge give enable=1 and level < threshold.
- R4: The drain request is 1 exactly when the drain enable and fill level sampled at the previous clock edge give enable=1 and level >= threshold.
- R5: The refill and drain requests are never 1 in the same cycle.
- R6: An overflow pulse sets the overflow flag from the next cycle on, and an underflow pulse does the same for the underflow flag. A flag stays set until it is cleared.
- R7: The clear register sits at offset 0x30. Writing 1 to bit 6 clears the underflow flag, and writing 1 to bit 5 clears the overflow flag.
- R8: Writing 0 to bit 5 or bit 6 of the clear register leaves the matching flag unchanged. Bits 7 and 4..0 of that register are ignored.
- R9: When an event pulse and a clear of the same flag fall in the same cycle, the flag ends up set.
- R10: A read of offset 0x30 returns 0.
- R11: A request drops in the cycle after the clock edge at which its condition stops holding, not earlier and not later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_level | input | 8 | Current FIFO fill level |
| ovf_pulse | input | 1 | One-cycle FIFO overflow event |
| unf_pulse | input | 1 | One-cycle FIFO underflow event |
| refill_en | input | 1 | Enable for the refill request |
| drain_en | input | 1 | Enable for the drain request |
| bus_addr | input | 6 | Byte offset inside the block window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| refill_req | output | 1 | Request to the DMA controller to fill the FIFO |
| drain_req | output | 1 | Request to the DMA controller to empty the FIFO |
| ovf_flag | output | 1 | Sticky overflow status |
| unf_flag | output | 1 | Sticky underflow status |

## Verification
Two functions can act on the same flag in one cycle: an event pulse setting it and a clear-register write resetting it. The bench drives an overflow pulse at the same time as a write with bit 5 set. It expects the flag to read 1 after that edge, and only a later clear on its own is expected to drop it. The refill and drain comparisons also meet at the threshold. The bench steps the level from threshold minus one to the threshold with both enables high, and checks at every cycle that exactly one request is active.

// File: rtl/fta_pkg.sv
package fta_pkg;
  localparam int unsigned ADDR_W  = 6;
  localparam int unsigned DATA_W  = 8;
  localparam logic [ADDR_W-1:0] OFS_CLEAR = 6'h30;
  localparam logic [ADDR_W-1:0] OFS_ALARM = 6'h34;
  localparam int unsigned BIT_UNF_CLR = 6;
  localparam int unsigned BIT_OVF_CLR = 5;
  localparam int unsigned NUM_FLAGS   = 2;
  localparam int unsigned FLG_OVF = 0;
  localparam int unsigned FLG_UNF = 1;
endpackage

// File: rtl/fta_regs.sv
module fta_regs
  import fta_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] alarm_q,
  output logic [NUM_FLAGS-1:0] clr_vec
);
  logic alarm_wr_hit;
  logic clear_wr_hit;

  assign alarm_wr_hit = bus_wr && (bus_addr == OFS_ALARM);
  assign clear_wr_hit = bus_wr && (bus_addr == OFS_CLEAR);

  always_ff @(posedge clk) begin
    if (!rst_n)            alarm_q <= '0;
    else if (alarm_wr_hit) alarm_q <= bus_wdata;
  end

  always_comb begin
    clr_vec          = '0;
    clr_vec[FLG_OVF] = clear_wr_hit && bus_wdata[BIT_OVF_CLR];
    clr_vec[FLG_UNF] = clear_wr_hit && bus_wdata[BIT_UNF_CLR];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && (bus_addr == OFS_ALARM)) bus_rdata = alarm_q;
  end

  // R2
  alarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_wr_hit |=> $stable(alarm_q));

  // R10
  clear_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_CLEAR) |-> bus_rdata == '0);
endmodule

// File: rtl/fta_sticky.sv
module fta_sticky
  import fta_pkg::*;
#(
  parameter int unsigned N = NUM_FLAGS
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (set_vec[i]) flag_q[i] <= 1'b1;
      else if (clr_vec[i]) flag_q[i] <= 1'b0;
    end

    // R6
    set_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flag_q[i]);

    // R9
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec[i] && clr_vec[i]) |=> flag_q[i]);

    // R7
    clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !flag_q[i]);

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_vec[i] && !set_vec[i]) |=> $stable(flag_q[i]));
  end
endmodule

// File: rtl/fta_req.sv
module fta_req
  import fta_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] fifo_level,
  input  logic              refill_en,
  input  logic              drain_en,
  input  logic [DATA_W-1:0] alarm_q,
  output logic              refill_req,
  output logic              drain_req
);
  logic [DATA_W-1:0] level_q;
  logic              refill_en_q;
  logic              drain_en_q;

  function automatic logic below_alarm(input logic [DATA_W-1:0] lvl,
                                       input logic [DATA_W-1:0] thr);
    return lvl < thr;
  endfunction

  function automatic logic at_or_over_alarm(input logic [DATA_W-1:0] lvl,
                                            input logic [DATA_W-1:0] thr);
    return !(lvl < thr);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q     <= '0;
      refill_en_q <= 1'b0;
      drain_en_q  <= 1'b0;
    end else begin
      level_q     <= fifo_level;
      refill_en_q <= refill_en;
      drain_en_q  <= drain_en;
    end
  end

  assign refill_req = refill_en_q && below_alarm(level_q, alarm_q);
  assign drain_req  = drain_en_q  && at_or_over_alarm(level_q, alarm_q);

  // R5
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(refill_req && drain_req));

  // R3
  refill_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !refill_en |=> !refill_req);

  // R4
  drain_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drain_en |=> !drain_req);
endmodule

// File: rtl/fta_ctrl.sv
module fta_ctrl
  import fta_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] fifo_level,
  input  logic              ovf_pulse,
  input  logic              unf_pulse,
  input  logic              refill_en,
  input  logic              drain_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              refill_req,
  output logic              drain_req,
  output logic              ovf_flag,
  output logic              unf_flag
);
  logic [DATA_W-1:0]    alarm_q;
  logic [NUM_FLAGS-1:0] clr_vec;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] flag_q;

  always_comb begin
    set_vec          = '0;
    set_vec[FLG_OVF] = ovf_pulse;
    set_vec[FLG_UNF] = unf_pulse;
  end

  fta_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alarm_q(alarm_q), .clr_vec(clr_vec)
  );

  fta_sticky #(.N(NUM_FLAGS)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .flag_q(flag_q)
  );

  fta_req u_req (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level),
    .refill_en(refill_en), .drain_en(drain_en), .alarm_q(alarm_q),
    .refill_req(refill_req), .drain_req(drain_req)
  );

  assign ovf_flag = flag_q[FLG_OVF];
  assign unf_flag = flag_q[FLG_UNF];

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!ovf_flag && !unf_flag && !refill_req && !drain_req));
endmodule

// File: tb/sim_fta_ctrl.sv
module sim_fta_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] fifo_level;
  logic       ovf_pulse, unf_pulse, refill_en, drain_en;
  logic [5:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic       refill_req, drain_req, ovf_flag, unf_flag;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fta_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .ovf_pulse(ovf_pulse),
    .unf_pulse(unf_pulse), .refill_en(refill_en), .drain_en(drain_en),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .refill_req(refill_req),
    .drain_req(drain_req), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    bus_read(6'h34, d);
    check("R1 alarm", d, 8'h00);
    check("R1 flags", {6'b0, ovf_flag, unf_flag}, 8'h00);
    check("R1 reqs", {6'b0, refill_req, drain_req}, 8'h00);
  endtask

  task automatic t_alarm_rw();
    logic [7:0] d;
    bus_write(6'h34, 8'hA5);
    bus_read(6'h34, d);
    check("R2 A5", d, 8'hA5);
    bus_write(6'h34, 8'h5A);
    bus_read(6'h34, d);
    check("R2 5A", d, 8'h5A);
    bus_read(6'h30, d);
    check("R10 clear reads 0", d, 8'h00);
  endtask

  task automatic t_requests();
    bus_write(6'h34, 8'd10);
    fifo_level = 8'd3; refill_en = 1'b1; drain_en = 1'b0;
    tick();
    check("R3 low level refill", {7'b0, refill_req}, 8'd1);
    check("R4 drain disabled", {7'b0, drain_req}, 8'd0);
    refill_en = 1'b0;
    tick();
    check("R3 refill disabled", {7'b0, refill_req}, 8'd0);
    refill_en = 1'b1; drain_en = 1'b1; fifo_level = 8'd9;
    tick();
    check("R5 level9", {6'b0, refill_req, drain_req}, 8'b10);
    fifo_level = 8'd10;
    #1 check("R11 refill holds before edge", {7'b0, refill_req}, 8'd1);
    tick();
    check("R11/R4 level10 drain", {6'b0, refill_req, drain_req}, 8'b01);
    fifo_level = 8'd255;
    tick();
    check("R4 level255", {6'b0, refill_req, drain_req}, 8'b01);
    fifo_level = 8'd0; drain_en = 1'b0;
    tick();
    check("R3 level0", {6'b0, refill_req, drain_req}, 8'b10);
    refill_en = 1'b0;
    tick();
  endtask

  task automatic t_sticky();
    ovf_pulse = 1'b1; tick(); ovf_pulse = 1'b0;
    check("R6 ovf set", {7'b0, ovf_flag}, 8'd1);
    check("R6 unf untouched", {7'b0, unf_flag}, 8'd0);
    unf_pulse = 1'b1; tick(); unf_pulse = 1'b0;
    tick();
    check("R6 both held", {6'b0, ovf_flag, unf_flag}, 8'b11);
    bus_write(6'h30, 8'h9F);
    check("R8 reserved bits ignored", {6'b0, ovf_flag, unf_flag}, 8'b11);
    bus_write(6'h30, 8'h40);
    check("R7 unf cleared only", {6'b0, ovf_flag, unf_flag}, 8'b10);
    bus_write(6'h30, 8'h20);
    check("R7 ovf cleared", {6'b0, ovf_flag, unf_flag}, 8'b00);
  endtask

  task automatic t_collide();
    ovf_pulse = 1'b1;
    bus_write(6'h30, 8'h20);
    ovf_pulse = 1'b0;
    check("R9 set wins ovf", {7'b0, ovf_flag}, 8'd1);
    unf_pulse = 1'b1;
    bus_write(6'h30, 8'h60);
    unf_pulse = 1'b0;
    check("R9 set wins unf, ovf cleared", {6'b0, ovf_flag, unf_flag}, 8'b01);
    bus_write(6'h30, 8'h40);
    check("R7 later clear", {7'b0, unf_flag}, 8'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fifo_level = '0; ovf_pulse = 0; unf_pulse = 0;
    refill_en = 0; drain_en = 0; bus_addr = '0; bus_wr = 0; bus_rd = 0;
    bus_wdata = '0;
    @(negedge clk); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_alarm_rw();
    t_requests();
    t_sticky();
    t_collide();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule